// File: doc/BRIEF.md
# Video Timing Reference Flag Extractor

This block sits on a 10-bit parallel digital video stream that carries one interleaved channel at one word per clock. It watches for timing reference sequences: three preamble words (all ones, all zeros, all zeros) followed by an ID word. From each ID word it decodes the horizontal blanking, vertical blanking and field bits. It then presents them as three registered status flags, aligned word for word with a delayed copy of the video.

Two shapes of the horizontal flag are offered. In span style, the flag covers the whole blanking gap, including every word of both the end-of-active and start-of-active sequences. In ID-bit style, the flag follows only the H bit carried by the ID words. A source select replaces all three flags with timing supplied by an external flywheel generator. Tracking of the received stream continues while the flywheel source is in use, so switching back gives current flags at once. The system ties `hstyle_sel` low for the default span style.

Top module: `video_trs_flags`

## Requirements
- R1: While `rst` is high at a clock edge, `vid_out`, `blank_h`, `blank_v` and `field_f` are all zero after that edge.
- R2: `vid_out` equals the `vid_in` word sampled five rising edges earlier.
- R3: With `hstyle_sel` = 0 and `fly_sel` = 0, `blank_h` is 1 for every word shown on `vid_out` from the all-ones preamble word of an EAV up to and including the ID word of the following SAV.
- R4: With `hstyle_sel` = 0 and `fly_sel` = 0, `blank_h` returns to 0 on the word that follows the SAV ID word at `vid_out`.
- R5: With `hstyle_sel` = 1 and `fly_sel` = 0, `blank_h` rises together with the EAV ID word at `vid_out`, stays 1 through the word before the SAV ID word, and is 0 on the SAV ID word.
- R6: An ID word has bit 9 = 1, bit 8 = F, bit 7 = V and bit 6 = H (H = 1 marks an EAV, H = 0 an SAV). With `fly_sel` = 0, `blank_v` and `field_f` take V and F on the cycle that ID word appears at `vid_out`, and hold them until the next ID word.
- R7: A word run that is not the full preamble 0x3FF, 0x000, 0x000 (for example 0x3FF, 0x000 and then a word with bit 9 set) changes none of the flags.
- R8: A full preamble followed by a word whose bit 9 is 0 is not a timing reference and changes none of the flags.
- R9: When `fly_sel` is 1 at a rising edge, `blank_h`, `blank_v` and `field_f` after that edge equal `fly_h`, `fly_v` and `fly_f` sampled at that edge.
- R10: When `fly_sel` returns to 0, the flags after the next edge show the state tracked from the received stream, which kept updating while the flywheel source was in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 10 | Incoming video word |
| hstyle_sel | input | 1 | Horizontal flag style: 0 span, 1 ID-bit |
| fly_sel | input | 1 | Flag source: 0 received stream, 1 flywheel inputs |
| fly_h | input | 1 | Flywheel horizontal blanking |
| fly_v | input | 1 | Flywheel vertical blanking |
| fly_f | input | 1 | Flywheel field |
| vid_out | output | 10 | Video word delayed to line up with the flags |
| blank_h | output | 1 | Horizontal blanking flag |
| blank_v | output | 1 | Vertical blanking flag |
| field_f | output | 1 | Field flag |

## Verification
One word stream is played twice, once in each horizontal style. It holds an EAV/SAV pair with V set and another with F set, so the two styles can be told apart by where `blank_h` starts and stops. The V and F columns show whether the ID bits are read from the correct positions. Between the two pairs the stream places a preamble cut short by a word with bit 9 set, and a full preamble ended by a word with bit 9 clear. Any flag movement there points to loose preamble matching or a missing bit-9 test. Directed steps then drive two different flywheel patterns and a return to the received source, which shows whether the mux takes effect after one edge and whether tracking survived the switch.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    localparam int WORD_W  = 10;
    localparam int PRE_LEN = 3;

    localparam int ID_ONE_B = WORD_W - 1;
    localparam int ID_F_B   = WORD_W - 2;
    localparam int ID_V_B   = WORD_W - 3;
    localparam int ID_H_B   = WORD_W - 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic h;
        logic v;
        logic f;
    } tflags_t;

    typedef enum logic {
        HSTYLE_SPAN  = 1'b0,
        HSTYLE_IDBIT = 1'b1
    } hstyle_e;

    localparam word_t MARK_ONES = '1;
    localparam word_t MARK_ZERO = '0;

    function automatic logic is_id_word(word_t w);
        return w[ID_ONE_B];
    endfunction

    function automatic tflags_t id_flags(word_t w);
        tflags_t r;
        r.h = w[ID_H_B];
        r.v = w[ID_V_B];
        r.f = w[ID_F_B];
        return r;
    endfunction

endpackage

// File: rtl/vtf_trs_detect.sv
module vtf_trs_detect
    import vtf_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = PRE_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] tail_word,
    output logic [W-1:0] head_word,
    output logic         hit,
    output logic         id_at_tail
);

    logic [W-1:0] stage [DEPTH+1];
    logic [DEPTH-1:0] hit_dly;
    logic zeros_ok;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= word_in;
    end

    for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[k] <= '0;
            else     stage[k] <= stage[k-1];
        end
    end

    always_comb begin
        zeros_ok = 1'b1;
        for (int k = 1; k < DEPTH; k++) begin
            if (stage[k] != '0) zeros_ok = 1'b0;
        end
    end

    assign hit = (stage[DEPTH] == '1) && zeros_ok && stage[0][W-1];

    always_ff @(posedge clk) begin
        if (rst) hit_dly <= '0;
        else     hit_dly <= {hit_dly[DEPTH-2:0], hit};
    end

    assign id_at_tail = hit_dly[DEPTH-1];
    assign tail_word  = stage[DEPTH];
    assign head_word  = stage[0];

endmodule

// File: rtl/vtf_h_shaper.sv
module vtf_h_shaper
    import vtf_pkg::*;
#(
    parameter int DEPTH = PRE_LEN
) (
    input  logic    clk,
    input  logic    rst,
    input  hstyle_e style,
    input  logic    hit,
    input  logic    hit_h,
    input  logic    id_at_tail,
    input  logic    tail_h,
    output logic    h_next
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          gap_q;
    logic [CW-1:0] tail_cnt;
    logic          idh_q;
    logic          idh_next;
    logic          eav_hit;
    logic          sav_hit;
    logic          h_span;

    assign eav_hit = hit & hit_h;
    assign sav_hit = hit & ~hit_h;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q    <= 1'b0;
            tail_cnt <= '0;
        end else begin
            if (eav_hit)      gap_q <= 1'b1;
            else if (sav_hit) gap_q <= 1'b0;

            if (sav_hit)              tail_cnt <= CW'(DEPTH);
            else if (tail_cnt != '0)  tail_cnt <= tail_cnt - 1'b1;
        end
    end

    assign h_span   = eav_hit | sav_hit | gap_q | (tail_cnt != '0);
    assign idh_next = id_at_tail ? tail_h : idh_q;

    always_ff @(posedge clk) begin
        if (rst) idh_q <= 1'b0;
        else     idh_q <= idh_next;
    end

    always_comb begin
        case (style)
            HSTYLE_IDBIT: h_next = idh_next;
            default:      h_next = h_span;
        endcase
    end

endmodule

// File: rtl/vtf_vf_track.sv
module vtf_vf_track
    import vtf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  id_at_tail,
    input  word_t tail_word,
    output logic  v_next,
    output logic  f_next
);

    tflags_t held_q;
    tflags_t dec;

    assign dec    = id_flags(tail_word);
    assign v_next = id_at_tail ? dec.v : held_q.v;
    assign f_next = id_at_tail ? dec.f : held_q.f;

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else begin
            held_q.h <= 1'b0;
            held_q.v <= v_next;
            held_q.f <= f_next;
        end
    end

endmodule

// File: rtl/vtf_out_stage.sv
module vtf_out_stage
    import vtf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  word_t   tail_word,
    input  tflags_t trs_flags,
    input  logic    use_fly,
    input  tflags_t fly_flags,
    output word_t   word_q,
    output tflags_t flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= MARK_ZERO;
            flags_q <= '0;
        end else begin
            word_q  <= tail_word;
            flags_q <= use_fly ? fly_flags : trs_flags;
        end
    end

endmodule

// File: rtl/video_trs_flags.sv
module video_trs_flags
    import vtf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] vid_in,
    input  logic              hstyle_sel,
    input  logic              fly_sel,
    input  logic              fly_h,
    input  logic              fly_v,
    input  logic              fly_f,
    output logic [WORD_W-1:0] vid_out,
    output logic              blank_h,
    output logic              blank_v,
    output logic              field_f
);

    word_t   tail_w;
    word_t   head_w;
    logic    hit;
    logic    id_tail;
    logic    h_nx;
    logic    v_nx;
    logic    f_nx;
    tflags_t trs_fl;
    tflags_t fly_fl;
    tflags_t out_fl;
    word_t   out_w;
    hstyle_e style;

    assign style = hstyle_e'(hstyle_sel);

    vtf_trs_detect #(.W(WORD_W), .DEPTH(PRE_LEN)) u_det (
        .clk        (clk),
        .rst        (rst),
        .word_in    (vid_in),
        .tail_word  (tail_w),
        .head_word  (head_w),
        .hit        (hit),
        .id_at_tail (id_tail)
    );

    vtf_h_shaper #(.DEPTH(PRE_LEN)) u_hsh (
        .clk        (clk),
        .rst        (rst),
        .style      (style),
        .hit        (hit),
        .hit_h      (head_w[ID_H_B]),
        .id_at_tail (id_tail),
        .tail_h     (tail_w[ID_H_B]),
        .h_next     (h_nx)
    );

    vtf_vf_track u_vf (
        .clk        (clk),
        .rst        (rst),
        .id_at_tail (id_tail),
        .tail_word  (tail_w),
        .v_next     (v_nx),
        .f_next     (f_nx)
    );

    assign trs_fl = '{h: h_nx, v: v_nx, f: f_nx};
    assign fly_fl = '{h: fly_h, v: fly_v, f: fly_f};

    vtf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .tail_word (tail_w),
        .trs_flags (trs_fl),
        .use_fly   (fly_sel),
        .fly_flags (fly_fl),
        .word_q    (out_w),
        .flags_q   (out_fl)
    );

    assign vid_out = out_w;
    assign blank_h = out_fl.h;
    assign blank_v = out_fl.v;
    assign field_f = out_fl.f;

endmodule

// File: rtl/video_trs_flags_chk.sv
module video_trs_flags_chk
    import vtf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] vid_in,
    input logic              hstyle_sel,
    input logic              fly_sel,
    input logic              fly_h,
    input logic              fly_v,
    input logic              fly_f,
    input logic [WORD_W-1:0] vid_out,
    input logic              blank_h,
    input logic              blank_v,
    input logic              field_f
);

    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)             cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end

    // R2: five-edge word latency
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd5) |-> (vid_out == $past(vid_in, 5)));

    // R4: span style H only drops right after an SAV ID word left the output
    a_r4_span_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(fly_sel) && !$past(fly_sel, 2) && !$past(hstyle_sel) && !$past(hstyle_sel, 2)
         && $fell(blank_h)) |-> ($past(vid_out[ID_ONE_B]) && !$past(vid_out[ID_H_B])));

    // R5: ID-bit style H rises together with an EAV ID word
    a_r5_idbit_rise: assert property (@(posedge clk) disable iff (rst)
        (!$past(fly_sel) && !$past(fly_sel, 2) && $past(hstyle_sel) && $past(hstyle_sel, 2)
         && $rose(blank_h)) |-> (vid_out[ID_ONE_B] && vid_out[ID_H_B]));

    // R6: V only moves on an ID word and then carries its V bit
    a_r6_v_on_id: assert property (@(posedge clk) disable iff (rst)
        (!$past(fly_sel) && !$past(fly_sel, 2) && !$stable(blank_v))
        |-> (vid_out[ID_ONE_B] && (blank_v == vid_out[ID_V_B])));

    // R6: F only moves on an ID word and then carries its F bit
    a_r6_f_on_id: assert property (@(posedge clk) disable iff (rst)
        (!$past(fly_sel) && !$past(fly_sel, 2) && !$stable(field_f))
        |-> (vid_out[ID_ONE_B] && (field_f == vid_out[ID_F_B])));

    // R9: flywheel inputs pass through in one edge
    a_r9_fly_pass: assert property (@(posedge clk) disable iff (rst)
        $past(fly_sel) |-> (blank_h == $past(fly_h) && blank_v == $past(fly_v)
                            && field_f == $past(fly_f)));

endmodule

bind video_trs_flags video_trs_flags_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .vid_in     (vid_in),
    .hstyle_sel (hstyle_sel),
    .fly_sel    (fly_sel),
    .fly_h      (fly_h),
    .fly_v      (fly_v),
    .fly_f      (fly_f),
    .vid_out    (vid_out),
    .blank_h    (blank_h),
    .blank_v    (blank_v),
    .field_f    (field_f)
);

// File: tb/sim_video_trs_flags.sv
module sim_video_trs_flags;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] vid_in;
    logic       hstyle_sel;
    logic       fly_sel;
    logic       fly_h;
    logic       fly_v;
    logic       fly_f;
    logic [9:0] vid_out;
    logic       blank_h;
    logic       blank_v;
    logic       field_f;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    video_trs_flags u0 (
        .clk        (clk),
        .rst        (rst),
        .vid_in     (vid_in),
        .hstyle_sel (hstyle_sel),
        .fly_sel    (fly_sel),
        .fly_h      (fly_h),
        .fly_v      (fly_v),
        .fly_f      (fly_f),
        .vid_out    (vid_out),
        .blank_h    (blank_h),
        .blank_v    (blank_v),
        .field_f    (field_f)
    );

    localparam int TV_N = 39;
    localparam int LAT  = 5;
    // {word, H in span style, H in ID-bit style, V, F} for each word as it leaves vid_out
    localparam logic [13:0] TV [TV_N] = '{
        {10'h200, 4'b0000}, {10'h201, 4'b0000},
        {10'h3FF, 4'b1000}, {10'h000, 4'b1000}, {10'h000, 4'b1000}, {10'h2C0, 4'b1110},
        {10'h040, 4'b1110}, {10'h040, 4'b1110},
        {10'h3FF, 4'b1110}, {10'h000, 4'b1110}, {10'h000, 4'b1110}, {10'h280, 4'b1010},
        {10'h123, 4'b0010}, {10'h124, 4'b0010},
        {10'h3FF, 4'b0010}, {10'h000, 4'b0010}, {10'h2C0, 4'b0010}, {10'h100, 4'b0010},
        {10'h3FF, 4'b0010}, {10'h000, 4'b0010}, {10'h000, 4'b0010}, {10'h0C0, 4'b0010},
        {10'h111, 4'b0010}, {10'h112, 4'b0010},
        {10'h3FF, 4'b1010}, {10'h000, 4'b1010}, {10'h000, 4'b1010}, {10'h340, 4'b1101},
        {10'h050, 4'b1101},
        {10'h3FF, 4'b1101}, {10'h000, 4'b1101}, {10'h000, 4'b1101}, {10'h300, 4'b1001},
        {10'h155, 4'b0001}, {10'h156, 4'b0001},
        {10'h200, 4'b0001}, {10'h200, 4'b0001}, {10'h200, 4'b0001}, {10'h200, 4'b0001}
    };

    task automatic chk(input string req, input string what, input logic [9:0] act,
                       input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_h(input int style, input int j);
        if (j == 21)                 return "R8";
        if (j >= 14 && j <= 23)      return "R7";
        if (style == 0 && j == 12)   return "R4";
        if (style == 0 && j == 33)   return "R4";
        return (style == 0) ? "R3" : "R5";
    endfunction

    function automatic string tag_vf(input int j);
        if (j == 21)            return "R8";
        if (j >= 14 && j <= 23) return "R7";
        return "R6";
    endfunction

    task automatic do_reset(input logic style);
        rst        = 1'b1;
        hstyle_sel = style;
        fly_sel    = 1'b0;
        fly_h      = 1'b0;
        fly_v      = 1'b0;
        fly_f      = 1'b0;
        vid_in     = 10'h200;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset vid_out", vid_out, 10'h000);
        chk("R1", "reset flags", {7'd0, blank_h, blank_v, field_f}, 10'h000);
    endtask

    task automatic run_table(input int style);
        for (int i = 0; i < TV_N + LAT; i++) begin
            rst    = 1'b0;
            vid_in = (i < TV_N) ? TV[i][13:4] : 10'h200;
            @(posedge clk);
            #1;
            if (i >= LAT - 1 && (i - (LAT - 1)) < TV_N) begin
                int j;
                j = i - (LAT - 1);
                chk("R2", "vid_out", vid_out, TV[j][13:4]);
                chk(tag_h(style, j), "blank_h", {9'd0, blank_h},
                    {9'd0, (style == 0) ? TV[j][3] : TV[j][2]});
                chk(tag_vf(j), "blank_v", {9'd0, blank_v}, {9'd0, TV[j][1]});
                chk(tag_vf(j), "field_f", {9'd0, field_f}, {9'd0, TV[j][0]});
            end
        end
    endtask

    initial begin
        do_reset(1'b0);
        run_table(0);
        do_reset(1'b1);
        run_table(1);

        // R9: flywheel source, two patterns
        fly_sel = 1'b1; fly_h = 1'b1; fly_v = 1'b0; fly_f = 1'b0;
        @(posedge clk); #1;
        chk("R9", "fly pattern a", {7'd0, blank_h, blank_v, field_f}, 10'b100);
        fly_h = 1'b0; fly_v = 1'b1; fly_f = 1'b0;
        @(posedge clk); #1;
        chk("R9", "fly pattern b", {7'd0, blank_h, blank_v, field_f}, 10'b010);

        // flywheel selected across a new EAV; tracking continues underneath
        vid_in = 10'h3FF; @(posedge clk); #1;
        vid_in = 10'h000; @(posedge clk); #1;
        vid_in = 10'h000; @(posedge clk); #1;
        vid_in = 10'h2C0; @(posedge clk); #1;
        vid_in = 10'h040;
        repeat (5) begin @(posedge clk); #1; end
        chk("R9", "fly held over EAV", {7'd0, blank_h, blank_v, field_f}, 10'b010);
        fly_v = 1'b0; fly_h = 1'b0; fly_f = 1'b0;
        @(posedge clk); #1;
        chk("R9", "fly pattern c", {7'd0, blank_h, blank_v, field_f}, 10'b000);

        // R10: back to the received stream: EAV decoded with H=1, V=1, F=0
        fly_sel = 1'b0;
        @(posedge clk); #1;
        chk("R10", "return to stream", {7'd0, blank_h, blank_v, field_f}, 10'b110);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule